// File: doc/BRIEF.md
# Directory Entry Buffer Cache

This block is an on-die, four-way set-associative store for coherence-directory entries. The full directory lives in a large, slow stacked-DRAM region. The coherence engine presents a line address on the lookup port. On a hit, the buffer returns the entry for that line one cycle later. An entry is a two-bit coherence state, a four-bit sharer vector (one bit per node) and a flag that marks read-write shared lines.

On a miss, the lookup port stalls and the block issues one wide read to the backing store. The read returns the 16 entries of an aligned group of neighbouring lines. All of them are installed, spread over four consecutive sets with four entries per set. The demanded entry is then returned with the hit flag clear. The block is sized so that a few hundred kilobytes to a megabyte of on-die storage covers a directory tens of times larger.

Directory updates from the engine always pass through to the backing store. They also refresh the buffered copy when one exists. Two counters report the number of hits and misses.

Top module: `dir_entry_buffer`

## Requirements
- R1: After reset, lkReady is 1, rspValid and fillReqValid are 0, and hitCount and missCount are 0.
- R2: A lookup accepted (lkValid and lkReady high at a clock edge) on a buffered address raises rspValid with rspHit=1 on the next cycle, and rspEntry holds the buffered entry.
- R3: A lookup that misses drops lkReady until its response. It raises fillReqValid with fillReqAddr = lookup address shifted right by 4, and holds both until fillReqReady is seen. Each miss issues exactly one request.
- R4: fillData carries 16 entries, entry i in bits [7i+6:7i], for line address {fillReqAddr, i}. Each entry is packed as state in bits [1:0], sharers in bits [5:2] and the read-write-shared flag in bit 6. All 16 entries are installed. Line address a maps to set a[SET_W+1:2].
- R5: After the install, the miss is answered with rspValid=1, rspHit=0, and the demanded entry taken from the burst.
- R6: An install uses the lowest invalid way of the set first, and otherwise the tree pseudo-LRU victim. Hits and the demanded entry become most recently used.
- R7: A neighbour entry that is installed is left as the next victim of its set. In a full set, one fill therefore displaces at most one resident entry through neighbours, in addition to the slot the demanded entry takes.
- R8: A write is offered to the backing store on bsWrValid/bsWrAddr/bsWrEntry unchanged. wrReady equals bsWrReady while the lookup port is ready. A write not accepted changes nothing.
- R9: An accepted write to a buffered address replaces that entry. A write to an address that is not buffered allocates nothing.
- R10: hitCount and missCount each increase by one for every accepted lookup that hits or misses, respectively.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| lkValid | input | 1 | Lookup request |
| lkAddr | input | ADDR_W | Lookup line address |
| lkReady | output | 1 | Lookup port can accept |
| rspValid | output | 1 | Lookup response valid |
| rspHit | output | 1 | Response came from a hit |
| rspEntry | output | 7 | Returned directory entry |
| wrValid | input | 1 | Directory update request |
| wrAddr | input | ADDR_W | Update line address |
| wrEntry | input | 7 | Update entry value |
| wrReady | output | 1 | Update accepted |
| bsWrValid | output | 1 | Write toward backing store |
| bsWrAddr | output | ADDR_W | Backing write address |
| bsWrEntry | output | 7 | Backing write entry |
| bsWrReady | input | 1 | Backing store accepts write |
| fillReqValid | output | 1 | Group read request |
| fillReqAddr | output | ADDR_W-4 | Group address |
| fillReqReady | input | 1 | Backing store took the request |
| fillRspValid | input | 1 | Group data returned |
| fillData | input | 112 | Sixteen packed entries |
| hitCount | output | CNT_W | Hit counter |
| missCount | output | CNT_W | Miss counter |

## Verification
The bench builds a full set and then forces a conflicting group into it. It checks that the least recently used resident line is the one evicted and that the neighbour entries of that group churn through a single way. A design that put neighbours at the MRU end, or that always took way 0, would hit or miss on the wrong survivors. It also checks write-through and that there is no allocation on an absent write. A write refused by the backing store must leave the buffered copy untouched; a design that ignored the handshake would return the refused value. Every response is compared against a backing-store model in the bench, including the one-cycle hit latency and the group address of each fill.

// File: rtl/dbc_pkg.sv
package dbc_pkg;
  localparam int NODES   = 4;
  localparam int WAYS    = 4;
  localparam int WAY_W   = $clog2(WAYS);
  localparam int GROUP_W = 4;
  localparam int GROUP   = 1 << GROUP_W;

  typedef struct packed {
    logic             rws;
    logic [NODES-1:0] sharers;
    logic [1:0]       state;
  } dirEntry_t;

  localparam int ENTRY_W = $bits(dirEntry_t);

  typedef enum logic [2:0] {ST_IDLE, ST_REQ, ST_WAIT, ST_INST, ST_RESP} fillState_t;

  typedef struct packed {
    logic               touchHit;
    logic               capture;
    logic               install;
    logic [GROUP_W-1:0] insIdx;
    logic               respond;
    logic               wrUpdate;
  } dpCtrl_t;
endpackage

// File: rtl/dbc_datapath.sv
module dbc_datapath
  import dbc_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int SET_W  = 4
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  dpCtrl_t                  ctrl,
  input  logic [ADDR_W-1:0]        lkAddr,
  input  logic [ADDR_W-1:0]        pendAddr,
  input  logic [ADDR_W-1:0]        wrAddr,
  input  dirEntry_t                wrEntry,
  input  logic [GROUP*ENTRY_W-1:0] fillData,
  output logic                     lkHit,
  output dirEntry_t                rspEntry
);
  localparam int SETS  = 1 << SET_W;
  localparam int TAG_W = ADDR_W - SET_W;
  localparam int HI_LO = SET_W + 2;

  logic [TAG_W-1:0] tagQ   [SETS][WAYS];
  dirEntry_t        dataQ  [SETS][WAYS];
  logic [WAYS-1:0]  validQ [SETS];
  logic [2:0]       plruQ  [SETS];
  logic [GROUP*ENTRY_W-1:0] burstQ;
  dirEntry_t        rspEntryQ;

  function automatic logic [WAY_W-1:0] enc(input logic [WAYS-1:0] m);
    return m[0] ? 2'd0 : m[1] ? 2'd1 : m[2] ? 2'd2 : 2'd3;
  endfunction
  function automatic logic [WAY_W-1:0] victimOf(input logic [2:0] p);
    return p[0] ? (p[2] ? 2'd3 : 2'd2) : (p[1] ? 2'd1 : 2'd0);
  endfunction
  function automatic logic [2:0] touchMru(input logic [2:0] p, input logic [WAY_W-1:0] w);
    logic [2:0] n = p;
    if (!w[1]) begin n[0] = 1'b1; n[1] = (w == 2'd0); end
    else       begin n[0] = 1'b0; n[2] = (w == 2'd2); end
    return n;
  endfunction
  function automatic logic [2:0] markLru(input logic [2:0] p, input logic [WAY_W-1:0] w);
    logic [2:0] n = p;
    if (!w[1]) begin n[0] = 1'b0; n[1] = (w == 2'd1); end
    else       begin n[0] = 1'b1; n[2] = (w == 2'd3); end
    return n;
  endfunction

  logic [ADDR_W-1:0] insAddr;
  assign insAddr = {pendAddr[ADDR_W-1:GROUP_W], ctrl.insIdx};

  logic [SET_W-1:0] lkSet, wrSet, insSet;
  logic [TAG_W-1:0] lkTag, wrTag, insTag;
  assign lkSet  = lkAddr[SET_W+1:2];
  assign wrSet  = wrAddr[SET_W+1:2];
  assign insSet = insAddr[SET_W+1:2];
  assign lkTag  = {lkAddr[ADDR_W-1:HI_LO], lkAddr[1:0]};
  assign wrTag  = {wrAddr[ADDR_W-1:HI_LO], wrAddr[1:0]};
  assign insTag = {insAddr[ADDR_W-1:HI_LO], insAddr[1:0]};

  logic [WAYS-1:0] lkMatch, wrMatch, insMatch;
  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign lkMatch[w]  = validQ[lkSet][w]  && (tagQ[lkSet][w]  == lkTag);
    assign wrMatch[w]  = validQ[wrSet][w]  && (tagQ[wrSet][w]  == wrTag);
    assign insMatch[w] = validQ[insSet][w] && (tagQ[insSet][w] == insTag);
  end

  logic [WAY_W-1:0] lkWay, wrWay, insWay;
  logic             insPresent, insDemand;
  dirEntry_t        insData, demandData;
  always_comb begin
    lkWay      = enc(lkMatch);
    wrWay      = enc(wrMatch);
    insPresent = |insMatch;
    insDemand  = (ctrl.insIdx == pendAddr[GROUP_W-1:0]);
    if (insPresent)              insWay = enc(insMatch);
    else if (~&validQ[insSet])   insWay = enc(~validQ[insSet]);
    else                         insWay = victimOf(plruQ[insSet]);
    insData    = burstQ[int'(ctrl.insIdx)*ENTRY_W +: ENTRY_W];
    demandData = burstQ[int'(pendAddr[GROUP_W-1:0])*ENTRY_W +: ENTRY_W];
  end

  assign lkHit    = |lkMatch;
  assign rspEntry = rspEntryQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int s = 0; s < SETS; s++) begin
        validQ[s] <= '0;
        plruQ[s]  <= '0;
        for (int w = 0; w < WAYS; w++) begin
          tagQ[s][w]  <= '0;
          dataQ[s][w] <= '0;
        end
      end
      burstQ    <= '0;
      rspEntryQ <= '0;
    end else begin
      if (ctrl.touchHit) begin
        plruQ[lkSet] <= touchMru(plruQ[lkSet], lkWay);
        rspEntryQ    <= dataQ[lkSet][lkWay];
      end
      if (ctrl.wrUpdate && |wrMatch) dataQ[wrSet][wrWay] <= wrEntry;
      if (ctrl.capture) burstQ <= fillData;
      if (ctrl.install) begin
        if (insDemand)        plruQ[insSet] <= touchMru(plruQ[insSet], insWay);
        else if (!insPresent) plruQ[insSet] <= markLru(plruQ[insSet], insWay);
        if (!insPresent) begin
          validQ[insSet][insWay] <= 1'b1;
          tagQ[insSet][insWay]   <= insTag;
          dataQ[insSet][insWay]  <= insData;
        end
      end
      if (ctrl.respond) rspEntryQ <= demandData;
    end
  end

  // R6: a tag is never buffered twice in one set
  a_r6_single_match: assert property (@(posedge clk) disable iff (!rstN) $onehot0(lkMatch));

  // R7: a neighbour that evicted must be the next victim of its set
  logic             lruChkQ;
  logic [SET_W-1:0] lruSetQ;
  logic [WAY_W-1:0] lruWayQ;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lruChkQ <= 1'b0; lruSetQ <= '0; lruWayQ <= '0;
    end else begin
      lruChkQ <= ctrl.install && !insDemand && !insPresent && (&validQ[insSet]);
      lruSetQ <= insSet;
      lruWayQ <= insWay;
    end
  end
  a_r7_neighbour_is_victim: assert property (@(posedge clk) disable iff (!rstN)
    lruChkQ |-> (victimOf(plruQ[lruSetQ]) == lruWayQ));
endmodule

// File: rtl/dbc_control.sv
module dbc_control
  import dbc_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int CNT_W  = 16
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  lkValid,
  input  logic [ADDR_W-1:0]     lkAddr,
  input  logic                  lkHit,
  output logic                  lkReady,
  output logic                  rspValid,
  output logic                  rspHit,
  input  logic                  wrValid,
  output logic                  wrReady,
  output logic                  bsWrValid,
  input  logic                  bsWrReady,
  output logic                  fillReqValid,
  output logic [ADDR_W-GROUP_W-1:0] fillReqAddr,
  input  logic                  fillReqReady,
  input  logic                  fillRspValid,
  output logic [ADDR_W-1:0]     pendAddr,
  output dpCtrl_t               ctrl,
  output logic [CNT_W-1:0]      hitCount,
  output logic [CNT_W-1:0]      missCount
);
  fillState_t         stateQ;
  logic [ADDR_W-1:0]  pendAddrQ;
  logic [GROUP_W-1:0] idxQ;
  logic [CNT_W-1:0]   hitQ, missQ;
  logic               rspValidQ, rspHitQ;
  logic               accept;

  always_comb begin
    lkReady       = (stateQ == ST_IDLE);
    accept        = lkValid && lkReady;
    ctrl          = '0;
    ctrl.touchHit = accept && lkHit;
    ctrl.capture  = (stateQ == ST_WAIT) && fillRspValid;
    ctrl.install  = (stateQ == ST_INST);
    ctrl.insIdx   = idxQ;
    ctrl.respond  = (stateQ == ST_RESP);
    ctrl.wrUpdate = wrValid && lkReady && bsWrReady;
  end

  assign fillReqValid = (stateQ == ST_REQ);
  assign fillReqAddr  = pendAddrQ[ADDR_W-1:GROUP_W];
  assign bsWrValid    = wrValid && lkReady;
  assign wrReady      = bsWrReady && lkReady;
  assign pendAddr     = pendAddrQ;
  assign rspValid     = rspValidQ;
  assign rspHit       = rspHitQ;
  assign hitCount     = hitQ;
  assign missCount    = missQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ <= ST_IDLE; pendAddrQ <= '0; idxQ <= '0;
      hitQ <= '0; missQ <= '0; rspValidQ <= 1'b0; rspHitQ <= 1'b0;
    end else begin
      rspValidQ <= ctrl.touchHit || ctrl.respond;
      rspHitQ   <= ctrl.touchHit;
      unique case (stateQ)
        ST_IDLE: if (accept) begin
          if (lkHit) hitQ <= hitQ + 1'b1;
          else begin
            missQ     <= missQ + 1'b1;
            pendAddrQ <= lkAddr;
            stateQ    <= ST_REQ;
          end
        end
        ST_REQ:  if (fillReqReady) stateQ <= ST_WAIT;
        ST_WAIT: if (fillRspValid) begin idxQ <= '0; stateQ <= ST_INST; end
        ST_INST: begin
          idxQ <= idxQ + 1'b1;
          if (idxQ == GROUP_W'(GROUP-1)) stateQ <= ST_RESP;
        end
        ST_RESP: stateQ <= ST_IDLE;
        default: stateQ <= ST_IDLE;
      endcase
    end
  end

  // R2: a hit answers on the next cycle
  a_r2_hit_next_cycle: assert property (@(posedge clk) disable iff (!rstN)
    (lkValid && lkReady && lkHit) |=> (rspValid && rspHit));
  // R3: the lookup port stays closed while a group read is pending
  a_r3_stall_on_fill: assert property (@(posedge clk) disable iff (!rstN)
    fillReqValid |-> !lkReady);
  // R3: the request and its address hold until taken
  a_r3_req_hold: assert property (@(posedge clk) disable iff (!rstN)
    (fillReqValid && !fillReqReady) |=> (fillReqValid && $stable(fillReqAddr)));
  // R10: each new group read follows one counted miss
  a_r10_miss_counted: assert property (@(posedge clk) disable iff (!rstN)
    $rose(fillReqValid) |-> (missCount == $past(missCount) + CNT_W'(1)));
endmodule

// File: rtl/dir_entry_buffer.sv
module dir_entry_buffer
  import dbc_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int SET_W  = 4,
  parameter int CNT_W  = 16
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          lkValid,
  input  logic [ADDR_W-1:0]             lkAddr,
  output logic                          lkReady,
  output logic                          rspValid,
  output logic                          rspHit,
  output logic [ENTRY_W-1:0]            rspEntry,
  input  logic                          wrValid,
  input  logic [ADDR_W-1:0]             wrAddr,
  input  logic [ENTRY_W-1:0]            wrEntry,
  output logic                          wrReady,
  output logic                          bsWrValid,
  output logic [ADDR_W-1:0]             bsWrAddr,
  output logic [ENTRY_W-1:0]            bsWrEntry,
  input  logic                          bsWrReady,
  output logic                          fillReqValid,
  output logic [ADDR_W-GROUP_W-1:0]     fillReqAddr,
  input  logic                          fillReqReady,
  input  logic                          fillRspValid,
  input  logic [GROUP*ENTRY_W-1:0]      fillData,
  output logic [CNT_W-1:0]              hitCount,
  output logic [CNT_W-1:0]              missCount
);
  dpCtrl_t           ctrl;
  logic              lkHit;
  logic [ADDR_W-1:0] pendAddr;
  dirEntry_t         rspEntryS;

  assign bsWrAddr  = wrAddr;
  assign bsWrEntry = wrEntry;
  assign rspEntry  = rspEntryS;

  dbc_control #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_ctrl (
    .clk, .rstN, .lkValid, .lkAddr, .lkHit, .lkReady, .rspValid, .rspHit,
    .wrValid, .wrReady, .bsWrValid, .bsWrReady, .fillReqValid, .fillReqAddr,
    .fillReqReady, .fillRspValid, .pendAddr, .ctrl, .hitCount, .missCount
  );

  dbc_datapath #(.ADDR_W(ADDR_W), .SET_W(SET_W)) u_dp (
    .clk, .rstN, .ctrl, .lkAddr, .pendAddr, .wrAddr,
    .wrEntry(dirEntry_t'(wrEntry)), .fillData, .lkHit, .rspEntry(rspEntryS)
  );
endmodule

// File: tb/dir_entry_buffer_tb.sv
module dir_entry_buffer_tb;
  localparam int AW = 12;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #2 clk = ~clk;

  logic          lkValid = 0, wrValid = 0, bsWrReady = 1;
  logic          fillReqReady = 0, fillRspValid = 0;
  logic [AW-1:0] lkAddr = '0, wrAddr = '0;
  logic [6:0]    wrEntry = '0;
  logic [111:0]  fillData = '0;
  logic          lkReady, rspValid, rspHit, wrReady, bsWrValid, fillReqValid;
  logic [6:0]    rspEntry, bsWrEntry;
  logic [AW-1:0] bsWrAddr;
  logic [7:0]    fillReqAddr;
  logic [15:0]   hitCount, missCount;

  dir_entry_buffer u_dut (
    .clk, .rstN, .lkValid, .lkAddr, .lkReady, .rspValid, .rspHit, .rspEntry,
    .wrValid, .wrAddr, .wrEntry, .wrReady, .bsWrValid, .bsWrAddr, .bsWrEntry,
    .bsWrReady, .fillReqValid, .fillReqAddr, .fillReqReady, .fillRspValid,
    .fillData, .hitCount, .missCount
  );

  int total = 0, bad = 0, hitsExp = 0, missExp = 0, fillsSeen = 0;
  logic [7:0] expGrp = '0;
  logic [6:0] mem [0:(1<<AW)-1];

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // backing store: group reads
  initial begin
    forever begin
      @(negedge clk);
      if (fillReqValid) begin
        repeat (2) @(negedge clk);
        chk(fillReqValid && fillReqAddr == expGrp, "R3", "group address", int'(fillReqAddr), int'(expGrp));
        fillsSeen++;
        fillReqReady = 1;
        @(negedge clk);
        fillReqReady = 0;
        chk(!fillReqValid, "R3", "request dropped after handshake", int'(fillReqValid), 0);
        repeat (3) @(negedge clk);
        for (int i = 0; i < 16; i++) fillData[i*7 +: 7] = mem[{expGrp, i[3:0]}];
        fillRspValid = 1;
        @(negedge clk);
        fillRspValid = 0;
      end
    end
  end

  task automatic lookup(input logic [AW-1:0] a, input bit expHit, input string req);
    int waitN = 0;
    bit sawReady = 0;
    expGrp  = a[AW-1:4];
    lkValid = 1; lkAddr = a;
    @(negedge clk);
    lkValid = 0;
    while (!rspValid && waitN < 400) begin
      if (lkReady) sawReady = 1;
      @(negedge clk);
      waitN++;
    end
    chk(rspValid, req, "response seen", int'(rspValid), 1);
    chk(rspHit == expHit, req, "hit flag", int'(rspHit), int'(expHit));
    chk(rspEntry == mem[a], req, "entry", int'(rspEntry), int'(mem[a]));
    if (expHit) begin
      hitsExp++;
      chk(waitN == 0, "R2", "hit latency", waitN, 0);
    end else begin
      missExp++;
      chk(!sawReady, "R3", "port stalled during miss", int'(sawReady), 0);
    end
    @(negedge clk);
  endtask

  task automatic write(input logic [AW-1:0] a, input logic [6:0] v, input bit rdy);
    bsWrReady = rdy; wrValid = 1; wrAddr = a; wrEntry = v;
    #1;
    chk(bsWrValid && bsWrAddr == a && bsWrEntry == v, "R8", "forwarded write", int'(bsWrEntry), int'(v));
    chk(wrReady == rdy, "R8", "wrReady follows backing", int'(wrReady), int'(rdy));
    if (rdy) mem[a] = v;
    @(negedge clk);
    wrValid = 0; bsWrReady = 1;
  endtask

  initial begin
    repeat (400000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < (1 << AW); i++) mem[i] = 7'((i * 37 + 11) ^ (i >> 5));
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R1 reset state
    chk(lkReady, "R1", "lkReady", int'(lkReady), 1);
    chk(!rspValid && !fillReqValid, "R1", "idle outputs", int'({rspValid, fillReqValid}), 0);
    chk(hitCount == 0 && missCount == 0, "R1", "counters", int'(hitCount + missCount), 0);

    // R5 first miss, R4 whole group installed over sets 0..3
    lookup(12'h000, 0, "R5");
    for (int i = 0; i < 16; i++) lookup(12'(i), 1, "R4");

    // R4 another group over sets 8..11
    lookup(12'h3A5, 0, "R5");
    lookup(12'h3A0, 1, "R4");
    lookup(12'h3AA, 1, "R4");
    lookup(12'h3AF, 1, "R4");

    // R6/R7 conflicting group into full sets 0..3
    lookup(12'h040, 0, "R6");
    lookup(12'h043, 1, "R7");
    lookup(12'h040, 1, "R6");
    lookup(12'h001, 1, "R7");
    lookup(12'h003, 1, "R7");
    lookup(12'h047, 1, "R7");
    lookup(12'h005, 1, "R7");
    lookup(12'h006, 1, "R7");
    lookup(12'h007, 1, "R7");
    lookup(12'h04B, 1, "R7");
    lookup(12'h04F, 1, "R7");
    lookup(12'h00D, 1, "R7");
    lookup(12'h041, 0, "R7");
    lookup(12'h000, 0, "R6");

    // R8/R9 writes
    write(12'h3A0, 7'h55, 1);
    write(12'h3A1, 7'h2A, 0);
    write(12'h800, 7'h66, 1);
    lookup(12'h3A0, 1, "R9");
    lookup(12'h3A1, 1, "R8");
    lookup(12'h800, 0, "R9");

    // R10 counters, R3 one fill per miss
    chk(hitCount == 16'(hitsExp), "R10", "hitCount", int'(hitCount), hitsExp);
    chk(missCount == 16'(missExp), "R10", "missCount", int'(missCount), missExp);
    chk(fillsSeen == missExp, "R3", "fills per miss", fillsSeen, missExp);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule